// File: doc/BRIEF.md
# Counter-Fed Gray/Binary Code Converter

This block keeps an 8-bit binary up-counter and turns its value into one of several code forms. Each clock edge writes the chosen form into a parallel output register. A two-bit select picks the form:

- the plain binary count;
- its Gray encoding;
- a Gray-to-binary decode that treats the count as if it were a Gray word;
- a loop-back word, which encodes the count to Gray and then decodes it again.

The loop-back word must always equal the count that produced it, so it acts as a built-in consistency path for the two converters.

The counter can be stopped, or loaded from an external 8-bit value, so a system can start the code stream anywhere. The raw counter value is also brought out, which lets a consumer relate each registered code word to its source. Both the counter and the output register clear on a synchronous active-high reset.

Top module: `gcv_top`

## Requirements
- R1: When `rst` is high at a rising edge, both `count` and `result` read 0 after that edge.
- R2: When `rst` and `load_en` are low at an edge, `count` moves to `count + 1` modulo 256 if `cnt_en` is high, and otherwise holds its value.
- R3: When `load_en` is high (and `rst` low) at an edge, `count` takes `load_val`, whatever the state of `cnt_en`.
- R4: With `out_sel` = 2'b00 at an edge, `result` after that edge equals the `count` seen at that edge (plain binary).
- R5: With `out_sel` = 2'b01, `result` is the Gray form of `count`: bit 7 equals count bit 7, and each lower bit i is count[i] XOR count[i+1].
- R6: With `out_sel` = 2'b10, `result` is `count` decoded as a Gray word: bit 7 equals count bit 7, and each lower bit i is result[i+1] XOR count[i], rippling down from the MSB.
- R7: With `out_sel` = 2'b11, `result` is the Gray form of `count` decoded back to binary, and it equals `count`.
- R8: While `out_sel` stays 2'b01 and the counter steps by one, consecutive `result` words differ in exactly one bit, including the step from 255 to 0.
- R9: `result` changes only at a rising edge, and it reflects the `count` and `out_sel` sampled at that same edge, so it trails a counter change by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock (200 MHz target) |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter increment enable |
| load_en | input | 1 | Loads `load_val` into the counter; has priority over `cnt_en` |
| load_val | input | 8 | External start value for the counter |
| out_sel | input | 2 | Code form: 00 binary, 01 Gray, 10 Gray decode, 11 loop-back |
| result | output | 8 | Registered code word |
| count | output | 8 | Current binary counter value |

## Verification
The hardest case to reach from the ports is the single-bit-change property across the counter wrap from 255 to 0. A free run from reset needs 256 counting cycles in Gray mode before it gets there, and a random mix of loads and selects seldom holds Gray mode across that step. The stimulus therefore loads the counter a few codes below 255 and counts through the wrap in Gray mode, and it also runs an unbroken 260-cycle Gray sweep. It then repeats the wrap in decode and loop-back modes. Finally, a long random phase interleaves reset, load with and without enable, and select changes on every cycle, so that the one-cycle lag of R9 is checked at every kind of boundary.

// File: rtl/gcv_pkg.sv
package gcv_pkg;

   typedef enum logic [1:0] {
      SEL_BIN  = 2'b00,
      SEL_GRAY = 2'b01,
      SEL_DEC  = 2'b10,
      SEL_LOOP = 2'b11
   } out_sel_e;

   localparam int unsigned ARCH_RIPPLE = 0;
   localparam int unsigned ARCH_LOG    = 1;

endpackage

// File: rtl/gcv_counter.sv
module gcv_counter #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] cnt
);

   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (ld)
         cnt_d = ld_val;
      else if (en)
         cnt_d = cnt_q + ONE;
   end

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else
         cnt_q <= cnt_d;
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/gcv_bin2gray.sv
module gcv_bin2gray #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] bin,
   output logic [W-1:0] gray
);

   assign gray[W-1] = bin[W-1];

   for (genvar i = 0; i < W - 1; i++) begin : g_bit
      assign gray[i] = bin[i] ^ bin[i+1];
   end

endmodule

// File: rtl/gcv_gray2bin.sv
module gcv_gray2bin #(
   parameter int unsigned W    = 8,
   parameter int unsigned ARCH = gcv_pkg::ARCH_RIPPLE
) (
   input  logic [W-1:0] gray,
   output logic [W-1:0] bin
);

   localparam int unsigned NST = (W > 1) ? $clog2(W) : 1;

   if (ARCH == gcv_pkg::ARCH_RIPPLE) begin : g_ripple
      // Serial chain: each bit waits for the decoded bit above it.
      always_comb begin
         bin[W-1] = gray[W-1];
         for (int i = W - 2; i >= 0; i--)
            bin[i] = bin[i+1] ^ gray[i];
      end
   end else begin : g_log
      // Suffix-XOR in log2(W) doubling stages.
      logic [W-1:0] stage [NST+1];
      assign stage[0] = gray;
      for (genvar k = 0; k < NST; k++) begin : g_stage
         assign stage[k+1] = stage[k] ^ (stage[k] >> (1 << k));
      end
      assign bin = stage[NST];
   end

endmodule

// File: rtl/gcv_out_stage.sv
module gcv_out_stage #(
   parameter int unsigned W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  gcv_pkg::out_sel_e sel,
   input  logic [W-1:0]     w_bin,
   input  logic [W-1:0]     w_gray,
   input  logic [W-1:0]     w_dec,
   input  logic [W-1:0]     w_loop,
   output logic [W-1:0]     q
);

   logic [W-1:0] pick;
   logic [W-1:0] q_r;

   always_comb begin
      unique case (sel)
         gcv_pkg::SEL_BIN:  pick = w_bin;
         gcv_pkg::SEL_GRAY: pick = w_gray;
         gcv_pkg::SEL_DEC:  pick = w_dec;
         gcv_pkg::SEL_LOOP: pick = w_loop;
         default:           pick = w_bin;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         q_r <= '0;
      else
         q_r <= pick;
   end

   assign q = q_r;

endmodule

// File: rtl/gcv_top.sv
module gcv_top #(
   parameter int unsigned W        = 8,
   parameter int unsigned G2B_ARCH = gcv_pkg::ARCH_RIPPLE
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         cnt_en,
   input  logic         load_en,
   input  logic [W-1:0] load_val,
   input  logic [1:0]   out_sel,
   output logic [W-1:0] result,
   output logic [W-1:0] count
);

   if (W < 2) begin : g_bad_width
      $error("gcv_top: W must be at least 2");
   end
   if (G2B_ARCH > gcv_pkg::ARCH_LOG) begin : g_bad_arch
      $error("gcv_top: G2B_ARCH must be 0 (ripple) or 1 (log)");
   end

   logic [W-1:0] cnt_w;
   logic [W-1:0] gray_w;
   logic [W-1:0] dec_w;
   logic [W-1:0] loop_w;
   gcv_pkg::out_sel_e sel_e;

   assign sel_e = gcv_pkg::out_sel_e'(out_sel);

   gcv_counter #(.W(W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .en     (cnt_en),
      .ld     (load_en),
      .ld_val (load_val),
      .cnt    (cnt_w)
   );

   gcv_bin2gray #(.W(W)) u_enc (
      .bin  (cnt_w),
      .gray (gray_w)
   );

   gcv_gray2bin #(.W(W), .ARCH(G2B_ARCH)) u_dec (
      .gray (cnt_w),
      .bin  (dec_w)
   );

   gcv_gray2bin #(.W(W), .ARCH(G2B_ARCH)) u_loop (
      .gray (gray_w),
      .bin  (loop_w)
   );

   gcv_out_stage #(.W(W)) u_out (
      .clk    (clk),
      .rst    (rst),
      .sel    (sel_e),
      .w_bin  (cnt_w),
      .w_gray (gray_w),
      .w_dec  (dec_w),
      .w_loop (loop_w),
      .q      (result)
   );

   assign count = cnt_w;

endmodule

// File: rtl/gcv_checker.sv
module gcv_checker #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         rst,
   input logic         cnt_en,
   input logic         load_en,
   input logic [W-1:0] load_val,
   input logic [1:0]   out_sel,
   input logic [W-1:0] result,
   input logic [W-1:0] count
);

   logic past_rst = 1'b0;

   always_ff @(posedge clk) begin
      past_rst <= rst;
      if (past_rst) begin
         assert_reset_clear_R1: assert (count == '0 && result == '0)
            else $error("R1: state not cleared after reset");
      end
   end

   assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
      (cnt_en && !load_en) |=> count == W'($past(count) + 1'b1));

   assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (!cnt_en && !load_en) |=> $stable(count));

   assert_load_R3: assert property (@(posedge clk) disable iff (rst)
      load_en |=> count == $past(load_val));

   assert_bin_pass_R4: assert property (@(posedge clk) disable iff (rst)
      (out_sel == 2'b00) |=> result == $past(count));

   assert_gray_form_R5: assert property (@(posedge clk) disable iff (rst)
      (out_sel == 2'b01) |=> result == ($past(count) ^ ($past(count) >> 1)));

   // R6: re-encoding the decoded word must give back the input word.
   assert_dec_inverse_R6: assert property (@(posedge clk) disable iff (rst)
      (out_sel == 2'b10) |=> (result ^ (result >> 1)) == $past(count));

   assert_loop_back_R7: assert property (@(posedge clk) disable iff (rst)
      (out_sel == 2'b11) |=> result == $past(count));

   assert_one_bit_R8: assert property (@(posedge clk) disable iff (rst)
      ((out_sel == 2'b01) && cnt_en && !load_en) ##1 (out_sel == 2'b01)
      |=> $countones(result ^ $past(result)) == 1);

endmodule

bind gcv_top gcv_checker #(.W(W)) i_chk (.*);

// File: tb/test_gcv_top.sv
`timescale 1ns/1ps
module test_gcv_top;

   localparam int W = 8;
   localparam int MASK = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         cnt_en = 1'b0;
   logic         load_en = 1'b0;
   logic [W-1:0] load_val = '0;
   logic [1:0]   out_sel = 2'b00;
   logic [W-1:0] result;
   logic [W-1:0] count;

   gcv_top i_gcv_top (
      .clk      (clk),
      .rst      (rst),
      .cnt_en   (cnt_en),
      .load_en  (load_en),
      .load_val (load_val),
      .out_sel  (out_sel),
      .result   (result),
      .count    (count)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   int m_cnt  = 0;
   int m_res  = 0;
   int prev_src = 0;
   int prev_res = 0;
   bit prev_gray = 0;

   function automatic int to_gray(int v);
      int g = 0;
      for (int i = 0; i < W; i++) begin
         int hi = (i == W - 1) ? 0 : ((v >> (i + 1)) & 1);
         g |= (((v >> i) & 1) ^ hi) << i;
      end
      return g;
   endfunction

   function automatic int from_gray(int g);
      int b = 0;
      int run = 0;
      for (int i = W - 1; i >= 0; i--) begin
         run = run ^ ((g >> i) & 1);
         b |= run << i;
      end
      return b;
   endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   // One cycle: drive after a falling edge, update the model at the rising edge,
   // compare at the next falling edge.
   task automatic cyc(bit r, bit en, bit ld, int lv, int sel);
      int n_cnt, n_res, src;
      string ctag, rtag;
      rst = r; cnt_en = en; load_en = ld; load_val = W'(lv); out_sel = 2'(sel);
      @(posedge clk);
      src = m_cnt;
      if (r) begin
         n_cnt = 0; n_res = 0; ctag = "R1 count"; rtag = "R1 result";
      end else begin
         if (ld)      begin n_cnt = lv & MASK;          ctag = "R3 load"; end
         else if (en) begin n_cnt = (m_cnt + 1) & MASK; ctag = "R2 step"; end
         else         begin n_cnt = m_cnt;              ctag = "R2 hold"; end
         case (sel)
            0: begin n_res = src;                       rtag = "R4 R9 binary"; end
            1: begin n_res = to_gray(src);              rtag = "R5 R9 gray"; end
            2: begin n_res = from_gray(src);            rtag = "R6 R9 decode"; end
            default: begin n_res = from_gray(to_gray(src)); rtag = "R7 R9 loop"; end
         endcase
      end
      @(negedge clk);
      check(ctag, int'(count), n_cnt);
      check(rtag, int'(result), n_res);
      if (sel == 3 && !r) check("R7 equals source", int'(result), src);
      if (!r && sel == 1 && prev_gray && src == ((prev_src + 1) & MASK)) begin
         check("R8 single bit change", $countones(W'(int'(result) ^ prev_res)), 1);
      end
      prev_gray = !r && sel == 1;
      prev_src  = src;
      prev_res  = int'(result);
      m_cnt = n_cnt;
      m_res = n_res;
   endtask

   initial begin
      #(200000 * 5);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      @(negedge clk);
      repeat (3) cyc(1, 1, 0, 0, 0);
      // R4: binary pass-through while counting
      repeat (10) cyc(0, 1, 0, 0, 0);
      // R2: hold with enable low
      repeat (4) cyc(0, 0, 0, 0, 1);
      // R5, R8: full Gray sweep through the wrap
      repeat (260) cyc(0, 1, 0, 0, 1);
      // R3, R8: load near the top, count through 255 -> 0 in Gray mode
      cyc(0, 0, 1, 250, 1);
      repeat (10) cyc(0, 1, 0, 0, 1);
      // R3: load wins over enable
      cyc(0, 1, 1, 8'hA5, 2);
      // R6: decode sweep
      repeat (300) cyc(0, 1, 0, 0, 2);
      // R7: loop-back sweep including the wrap
      cyc(0, 1, 1, 252, 3);
      repeat (270) cyc(0, 1, 0, 0, 3);
      // R1: reset in the middle of a run
      cyc(1, 1, 1, 77, 1);
      cyc(0, 1, 0, 0, 1);
      // R9: select changes on every cycle
      for (int i = 0; i < 16; i++) cyc(0, 1, 0, 0, i % 4);
      // Random mix
      for (int i = 0; i < 1500; i++) begin
         cyc(($urandom % 64) == 0, ($urandom % 4) != 0, ($urandom % 16) == 0,
             int'($urandom % 256), int'($urandom % 4));
      end
      summary();
      $finish;
   end

endmodule